// File: doc/BRIEF.md
# Counting Accumulation Memory Endpoint

This block is the receiving end of a network client. Incoming packets either overwrite words of a local memory or add their words to the values already stored there. Every packet names one counter in a bank of synchronization counters. That counter advances by one only after the packet's last word has reached memory. A consumer that knows how many packets to expect can therefore poll one counter. When the counter matches its target, all of the data is present, and no separate handshake with the senders is needed.

A packet starts with a header that gives the opcode, the start address, the counter number and the length in 32-bit words (0 to 64, that is 0 to 256 bytes). A write of one or two words travels in a 64-bit field of the header and uses no payload beats. All other packets deliver their words one per cycle over a valid/ready payload channel. The words go to successive addresses, and the address wraps at the top of memory. A packet with no words still advances its counter, so it can act as a pure synchronization event.

A poll port reads any counter, compares it with an expected value, and can preset or clear a counter. A separate read port returns any memory word.

Top module: `count_accum_endpoint`

## Requirements
- R1: A write packet of length N stores its N payload words at addresses start, start+1, …, start+N−1, with the address taken modulo the memory depth (256 words by default).
- R2: An accumulate packet (opcode 1) adds each payload word to the stored word at its address using 32-bit two's-complement wraparound with no saturation; opcode 0 is a write.
- R3: A write packet of length 1 or 2 takes its data from the header's 64-bit inline field, first word in bits 31:0 and second in bits 63:32, and the payload channel stays not-ready for that packet.
- R4: The named counter rises by exactly one on the clock edge after the edge that commits the packet's last memory word, so memory already shows the new data while the counter still reads its old value.
- R5: A zero-length packet leaves memory unchanged and still advances its counter by one.
- R6: The poll port returns the current value of the selected counter combinationally, and its hit output is 1 exactly when that value equals the expected value.
- R7: A poll-port preset loads the selected counter on the next edge, and it wins over an increment of the same counter in that cycle.
- R8: Counters are 16 bits wide and wrap from 0xFFFF to 0x0000.
- R9: After reset all counters read zero, the header channel is ready and the payload channel is not ready.
- R10: While a packet's words are being received, headers are refused, and a payload word is taken only in a cycle where payload valid is high; a gap stalls the packet without advancing its counter.
- R11: A packet of the maximum length, 64 words, is received in full and advances its counter once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdr_valid | input | 1 | Header present |
| hdr_ready | output | 1 | Header accepted this cycle when valid |
| hdr_op | input | 1 | 0 = write, 1 = accumulate |
| hdr_addr | input | 8 | Start word address |
| hdr_cnt_id | input | 5 | Counter to advance |
| hdr_len | input | 7 | Length in 32-bit words, 0 to 64 |
| hdr_inline | input | 64 | Inline data for writes of 1 or 2 words |
| pay_valid | input | 1 | Payload word present |
| pay_ready | output | 1 | Payload word accepted this cycle when valid |
| pay_data | input | 32 | Payload word |
| poll_id | input | 5 | Counter selected for poll or preset |
| poll_count | output | 16 | Value of the selected counter |
| poll_expect | input | 16 | Target count for comparison |
| poll_hit | output | 1 | Selected counter equals target |
| poll_wr_en | input | 1 | Preset the selected counter |
| poll_wr_data | input | 16 | Preset value |
| rd_addr | input | 8 | Memory readback address |
| rd_data | output | 32 | Memory word at rd_addr |

## Verification
The properties assume that the input side obeys the protocol. Header lengths never exceed 64 words. The poll selection stays unchanged across the edge that a preset or increment check spans. The bench respects both limits: every packet it sends is 64 words or shorter, and it changes `poll_id` only in cycles where no preset or increment is in flight. Each packet is offered only while the header channel is idle. Payload words are offered only after the header edge, and the bench inserts a deliberate one-cycle gap to exercise stalling.

// File: rtl/cae_pkg.sv
// Shared types for the counting accumulation endpoint.
package cae_pkg;
    typedef enum logic { OP_WRITE = 1'b0, OP_ACCUM = 1'b1 } cae_op_e;
    typedef enum logic { ST_IDLE = 1'b0, ST_BUSY = 1'b1 } cae_state_e;
    localparam int INLINE_WORDS = 2;
endpackage

// File: rtl/cae_rx_seq.sv
// Packet sequencer: takes a header, then emits one memory word per cycle
// from either the inline header field or the payload channel. It raises
// inc_v one edge after the final word is committed.
// Assumes hdr_len <= maximum packet length.
module cae_rx_seq
    import cae_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int ID_W   = 5,
    parameter int LEN_W  = 7,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_valid,
    output logic              hdr_ready,
    input  logic              hdr_op,
    input  logic [ADDR_W-1:0] hdr_addr,
    input  logic [ID_W-1:0]   hdr_cnt_id,
    input  logic [LEN_W-1:0]  hdr_len,
    input  logic [2*DATA_W-1:0] hdr_inline,
    input  logic              pay_valid,
    output logic              pay_ready,
    input  logic [DATA_W-1:0] pay_data,
    output logic              mem_we,
    output logic              mem_acc,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              inc_v,
    output logic [ID_W-1:0]   inc_id
);
    cae_state_e           state_q;
    cae_op_e              op_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [LEN_W-1:0]     remain_q;
    logic [ID_W-1:0]      id_q;
    logic                 inl_mode_q;
    logic                 widx_q;
    logic [2*DATA_W-1:0]  inl_q;
    logic                 hdr_fire;
    logic                 hdr_inl;

    // Channel readiness follows the sequencer state.
    always_comb begin
        hdr_ready = (state_q == ST_IDLE);
        pay_ready = (state_q == ST_BUSY) && !inl_mode_q;
        hdr_fire  = hdr_valid && hdr_ready;
        hdr_inl   = (cae_op_e'(hdr_op) == OP_WRITE) && (hdr_len <= LEN_W'(INLINE_WORDS));
    end

    // Memory word source: inline half-word or live payload.
    always_comb begin
        mem_we   = (state_q == ST_BUSY) && (inl_mode_q || pay_valid);
        mem_acc  = (op_q == OP_ACCUM);
        mem_addr = addr_q;
        mem_data = inl_mode_q ? (widx_q ? inl_q[2*DATA_W-1:DATA_W] : inl_q[DATA_W-1:0])
                              : pay_data;
    end

    // Header capture, word stepping and deferred counter request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            op_q       <= OP_WRITE;
            addr_q     <= '0;
            remain_q   <= '0;
            id_q       <= '0;
            inl_mode_q <= 1'b0;
            widx_q     <= 1'b0;
            inl_q      <= '0;
            inc_v      <= 1'b0;
            inc_id     <= '0;
        end else begin
            inc_v <= 1'b0;
            if (hdr_fire) begin
                if (hdr_len == '0) begin
                    inc_v  <= 1'b1;
                    inc_id <= hdr_cnt_id;
                end else begin
                    state_q <= ST_BUSY;
                end
                op_q       <= cae_op_e'(hdr_op);
                addr_q     <= hdr_addr;
                remain_q   <= hdr_len;
                id_q       <= hdr_cnt_id;
                inl_mode_q <= hdr_inl;
                widx_q     <= 1'b0;
                inl_q      <= hdr_inline;
            end else if (mem_we) begin
                addr_q   <= addr_q + 1'b1;
                remain_q <= remain_q - 1'b1;
                widx_q   <= 1'b1;
                if (remain_q == LEN_W'(1)) begin
                    state_q <= ST_IDLE;
                    inc_v   <= 1'b1;
                    inc_id  <= id_q;
                end
            end
        end
    end
endmodule

// File: rtl/cae_word_mem.sv
// Local word memory with a single-cycle read-modify-write port for
// accumulation and a combinational readback port. Contents are not reset.
module cae_word_mem #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic              acc,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;
    logic [DATA_W-1:0] mem_q [DEPTH];

    // Store or add-in-place, wrapping on overflow.
    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= acc ? (mem_q[addr] + wdata) : wdata;
    end

    // Readback for the local agent.
    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/cae_sync_counters.sv
// Bank of wrapping synchronization counters. A preset from the poll port
// has priority over an increment aimed at the same counter.
module cae_sync_counters #(
    parameter int CNT_N = 32,
    parameter int CNT_W = 16,
    parameter int ID_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_v,
    input  logic [ID_W-1:0]  inc_id,
    input  logic             wr_en,
    input  logic [ID_W-1:0]  wr_id,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [ID_W-1:0]  rd_id,
    output logic [CNT_W-1:0] rd_val
);
    logic [CNT_N*CNT_W-1:0] flat;

    for (genvar g = 0; g < CNT_N; g++) begin : g_cnt
        logic [CNT_W-1:0] val_q;
        // One counter: preset, else increment, else hold.
        always_ff @(posedge clk) begin
            if (!rst_n)
                val_q <= '0;
            else if (wr_en && (wr_id == ID_W'(g)))
                val_q <= wr_data;
            else if (inc_v && (inc_id == ID_W'(g)))
                val_q <= val_q + 1'b1;
        end
        assign flat[g*CNT_W +: CNT_W] = val_q;
    end

    // Read mux shows the value held before any pending update.
    assign rd_val = flat[rd_id*CNT_W +: CNT_W];
endmodule

// File: rtl/count_accum_endpoint.sv
// Receive endpoint: packets write or accumulate into local memory and each
// advances a named counter after its data is committed. A poll port reads,
// compares and presets counters.
module count_accum_endpoint #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int CNT_N     = 32,
    parameter int CNT_W     = 16,
    parameter int MAX_WORDS = 64,
    localparam int ID_W     = $clog2(CNT_N),
    localparam int LEN_W    = $clog2(MAX_WORDS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hdr_valid,
    output logic                hdr_ready,
    input  logic                hdr_op,
    input  logic [ADDR_W-1:0]   hdr_addr,
    input  logic [ID_W-1:0]     hdr_cnt_id,
    input  logic [LEN_W-1:0]    hdr_len,
    input  logic [2*DATA_W-1:0] hdr_inline,
    input  logic                pay_valid,
    output logic                pay_ready,
    input  logic [DATA_W-1:0]   pay_data,
    input  logic [ID_W-1:0]     poll_id,
    output logic [CNT_W-1:0]    poll_count,
    input  logic [CNT_W-1:0]    poll_expect,
    output logic                poll_hit,
    input  logic                poll_wr_en,
    input  logic [CNT_W-1:0]    poll_wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data
);
    logic              mem_we;
    logic              mem_acc;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_data;
    logic              inc_v;
    logic [ID_W-1:0]   inc_id;

    cae_rx_seq #(.ADDR_W(ADDR_W), .ID_W(ID_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_op(hdr_op),
        .hdr_addr(hdr_addr), .hdr_cnt_id(hdr_cnt_id), .hdr_len(hdr_len),
        .hdr_inline(hdr_inline),
        .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
        .mem_we(mem_we), .mem_acc(mem_acc), .mem_addr(mem_addr), .mem_data(mem_data),
        .inc_v(inc_v), .inc_id(inc_id)
    );

    cae_word_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .we(mem_we), .acc(mem_acc), .addr(mem_addr), .wdata(mem_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    cae_sync_counters #(.CNT_N(CNT_N), .CNT_W(CNT_W), .ID_W(ID_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .inc_v(inc_v), .inc_id(inc_id),
        .wr_en(poll_wr_en), .wr_id(poll_id), .wr_data(poll_wr_data),
        .rd_id(poll_id), .rd_val(poll_count)
    );

    // Completion compare for the polling agent.
    assign poll_hit = (poll_count == poll_expect);
endmodule

// File: rtl/cae_checker.sv
// Protocol and ordering properties for count_accum_endpoint, bound below.
module cae_checker #(
    parameter int CNT_W     = 16,
    parameter int ID_W      = 5,
    parameter int LEN_W     = 7,
    parameter int MAX_WORDS = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hdr_valid,
    input logic             hdr_ready,
    input logic             hdr_op,
    input logic [LEN_W-1:0] hdr_len,
    input logic             pay_ready,
    input logic             inc_v,
    input logic [ID_W-1:0]  inc_id,
    input logic [ID_W-1:0]  poll_id,
    input logic [CNT_W-1:0] poll_count,
    input logic             poll_wr_en,
    input logic [CNT_W-1:0] poll_wr_data
);
    assert_len_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ready) |-> (hdr_len <= LEN_W'(MAX_WORDS)));

    assert_busy_refuses_hdr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(hdr_ready && pay_ready));

    assert_zero_len_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ready && hdr_len == '0) |=> (hdr_ready && inc_v));

    assert_inline_no_payload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ready && !hdr_op && hdr_len != '0 && hdr_len <= LEN_W'(2))
        |=> !pay_ready);

    assert_inc_by_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_v && !poll_wr_en && poll_id == inc_id) ##1 $stable(poll_id)
        |-> poll_count == $past(poll_count) + 1'b1);

    assert_preset_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        poll_wr_en ##1 $stable(poll_id) |-> poll_count == $past(poll_wr_data));
endmodule

bind count_accum_endpoint cae_checker #(
    .CNT_W(CNT_W), .ID_W(ID_W), .LEN_W(LEN_W), .MAX_WORDS(MAX_WORDS)
) u_cae_checker (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_op(hdr_op), .hdr_len(hdr_len), .pay_ready(pay_ready),
    .inc_v(inc_v), .inc_id(inc_id), .poll_id(poll_id), .poll_count(poll_count),
    .poll_wr_en(poll_wr_en), .poll_wr_data(poll_wr_data)
);

// File: tb/count_accum_endpoint_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module count_accum_endpoint_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_valid = 1'b0;
    logic        hdr_ready;
    logic        hdr_op = 1'b0;
    logic [7:0]  hdr_addr = '0;
    logic [4:0]  hdr_cnt_id = '0;
    logic [6:0]  hdr_len = '0;
    logic [63:0] hdr_inline = '0;
    logic        pay_valid = 1'b0;
    logic        pay_ready;
    logic [31:0] pay_data = '0;
    logic [4:0]  poll_id = '0;
    logic [15:0] poll_count;
    logic [15:0] poll_expect = '0;
    logic        poll_hit;
    logic        poll_wr_en = 1'b0;
    logic [15:0] poll_wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int errors = 0;
    int checks = 0;
    logic [31:0] pbuf [64];
    logic saw_pay_ready;
    logic gap_hdr_ready;
    logic [15:0] gap_count;

    count_accum_endpoint u_count_accum_endpoint (
        .clk(clk), .rst_n(rst_n),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_op(hdr_op),
        .hdr_addr(hdr_addr), .hdr_cnt_id(hdr_cnt_id), .hdr_len(hdr_len),
        .hdr_inline(hdr_inline),
        .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
        .poll_id(poll_id), .poll_count(poll_count), .poll_expect(poll_expect),
        .poll_hit(poll_hit), .poll_wr_en(poll_wr_en), .poll_wr_data(poll_wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic count_of(input logic [4:0] id, output logic [15:0] v);
        poll_id = id;
        #1;
        v = poll_count;
    endtask

    // Sends one packet; returns at the falling edge right after the commit edge.
    task automatic send_pkt(input logic op, input logic [7:0] a, input logic [4:0] id,
                            input int len, input logic [63:0] inl, input int gap_at);
        @(negedge clk);
        hdr_op = op; hdr_addr = a; hdr_cnt_id = id; hdr_len = 7'(len);
        hdr_inline = inl; hdr_valid = 1'b1;
        @(negedge clk);
        hdr_valid = 1'b0;
        saw_pay_ready = 1'b0;
        if (len == 0) return;
        if (!op && len <= 2) begin
            pay_valid = 1'b1;
            pay_data = 32'hDEAD_BEEF;
            for (int i = 0; i < len; i++) begin
                if (pay_ready) saw_pay_ready = 1'b1;
                @(negedge clk);
            end
            pay_valid = 1'b0;
            return;
        end
        for (int i = 0; i < len; i++) begin
            if (i == gap_at) begin
                pay_valid = 1'b0;
                @(negedge clk);
                gap_hdr_ready = hdr_ready;
                gap_count = poll_count;
            end
            pay_valid = 1'b1;
            pay_data = pbuf[i];
            @(negedge clk);
        end
        pay_valid = 1'b0;
    endtask

    task automatic set_cnt(input logic [4:0] id, input logic [15:0] v);
        @(negedge clk);
        poll_id = id; poll_wr_en = 1'b1; poll_wr_data = v;
        @(negedge clk);
        poll_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 hdr_ready after reset", 64'(hdr_ready), 64'd1);
        check("R9 pay_ready after reset", 64'(pay_ready), 64'd0);
        count_of(5'd0, c);  check("R9 counter 0 after reset", 64'(c), 64'd0);
        count_of(5'd31, c); check("R9 counter 31 after reset", 64'(c), 64'd0);
    endtask

    task automatic t_write_wrap();
        logic [31:0] d;
        logic [15:0] c;
        pbuf[0] = 32'hA0A0_0001; pbuf[1] = 32'hA0A0_0002; pbuf[2] = 32'hA0A0_0003;
        poll_id = 5'd2;
        send_pkt(1'b0, 8'hFE, 5'd2, 3, 64'd0, -1);
        peek(8'hFE, d); check("R1 word at FE", 64'(d), 64'hA0A0_0001);
        peek(8'hFF, d); check("R1 word at FF", 64'(d), 64'hA0A0_0002);
        peek(8'h00, d); check("R1 word wrapped to 00", 64'(d), 64'hA0A0_0003);
        count_of(5'd2, c); check("R4 counter still old after commit", 64'(c), 64'd0);
        @(negedge clk);
        count_of(5'd2, c); check("R4 counter one edge later", 64'(c), 64'd1);
    endtask

    task automatic t_accum();
        logic [31:0] d;
        logic [15:0] c;
        pbuf[0] = 32'd5; pbuf[1] = 32'hFFFF_FFFF; pbuf[2] = 32'd100;
        send_pkt(1'b0, 8'h10, 5'd1, 3, 64'd0, -1);
        pbuf[0] = 32'd3; pbuf[1] = 32'd2; pbuf[2] = 32'hFFFF_FFFF;
        send_pkt(1'b1, 8'h10, 5'd1, 3, 64'd0, -1);
        peek(8'h10, d); check("R2 5+3", 64'(d), 64'd8);
        peek(8'h11, d); check("R2 wrap FFFFFFFF+2", 64'(d), 64'd1);
        peek(8'h12, d); check("R2 100 + (-1)", 64'(d), 64'd99);
        @(negedge clk);
        poll_expect = 16'd2;
        count_of(5'd1, c); check("R6 poll count two packets", 64'(c), 64'd2);
        check("R6 hit when equal", 64'(poll_hit), 64'd1);
        poll_expect = 16'd3; #1;
        check("R6 no hit when unequal", 64'(poll_hit), 64'd0);
    endtask

    task automatic t_inline_and_zero();
        logic [31:0] d;
        logic [15:0] c;
        send_pkt(1'b0, 8'h50, 5'd8, 2, 64'h2222_0000_1111_0000, -1);
        check("R3 payload not ready during inline", 64'(saw_pay_ready), 64'd0);
        peek(8'h50, d); check("R3 inline low word", 64'(d), 64'h1111_0000);
        peek(8'h51, d); check("R3 inline high word", 64'(d), 64'h2222_0000);
        @(negedge clk);
        count_of(5'd8, c); check("R3 inline counter", 64'(c), 64'd1);
        send_pkt(1'b0, 8'h30, 5'd6, 1, 64'h0000_0000_0000_1234, -1);
        poll_id = 5'd7;
        send_pkt(1'b1, 8'h30, 5'd7, 0, 64'hFFFF_FFFF_FFFF_FFFF, -1);
        count_of(5'd7, c); check("R5 zero-length old before edge", 64'(c), 64'd0);
        @(negedge clk);
        count_of(5'd7, c); check("R5 zero-length counts", 64'(c), 64'd1);
        peek(8'h30, d); check("R5 memory untouched", 64'(d), 64'h1234);
    endtask

    task automatic t_preset_wrap();
        logic [15:0] c;
        set_cnt(5'd9, 16'hFFFF);
        count_of(5'd9, c); check("R7 preset loads", 64'(c), 64'hFFFF);
        send_pkt(1'b0, 8'h00, 5'd9, 0, 64'd0, -1);
        @(negedge clk);
        count_of(5'd9, c); check("R8 wrap to zero", 64'(c), 64'd0);
        @(negedge clk);
        hdr_op = 1'b0; hdr_addr = 8'h00; hdr_cnt_id = 5'd4; hdr_len = 7'd0; hdr_valid = 1'b1;
        @(negedge clk);
        hdr_valid = 1'b0;
        poll_id = 5'd4; poll_wr_en = 1'b1; poll_wr_data = 16'h0055;
        @(negedge clk);
        poll_wr_en = 1'b0;
        count_of(5'd4, c); check("R7 preset beats increment", 64'(c), 64'h0055);
        @(negedge clk);
        count_of(5'd4, c); check("R7 increment dropped", 64'(c), 64'h0055);
    endtask

    task automatic t_stall_and_max();
        logic [31:0] d;
        logic [15:0] c;
        for (int i = 0; i < 4; i++) pbuf[i] = 32'hC000_0000 + 32'(i);
        poll_id = 5'd3;
        send_pkt(1'b0, 8'h20, 5'd3, 4, 64'd0, 2);
        check("R10 header refused mid-packet", 64'(gap_hdr_ready), 64'd0);
        check("R10 no count during gap", 64'(gap_count), 64'd0);
        peek(8'h22, d); check("R10 word after gap", 64'(d), 64'hC000_0002);
        peek(8'h23, d); check("R10 last word", 64'(d), 64'hC000_0003);
        @(negedge clk);
        count_of(5'd3, c); check("R10 single count after stall", 64'(c), 64'd1);
        for (int i = 0; i < 64; i++) pbuf[i] = 32'(i * 3 + 7);
        poll_id = 5'd5;
        send_pkt(1'b0, 8'h80, 5'd5, 64, 64'd0, -1);
        peek(8'h80, d); check("R11 first of 64", 64'(d), 64'd7);
        peek(8'hBF, d); check("R11 last of 64", 64'(d), 64'd196);
        @(negedge clk);
        count_of(5'd5, c); check("R11 counted once", 64'(c), 64'd1);
    endtask

    initial begin
        t_reset();
        t_write_wrap();
        t_accum();
        t_inline_and_zero();
        t_preset_wrap();
        t_stall_and_max();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule